// File: doc/BRIEF.md
# Direct-Mapped Read Cache Controller

This block sits between a requester and a word-wide backing memory. It serves reads only. Each incoming byte address is split into three unsigned fields: a tag, a line index and a byte offset. The indexed line is then checked for a stored tag that is valid and matches. When it matches, the selected word is returned straight from the cache. When it does not match, the controller reads the whole line from memory one word at a time, stores each word, records the new tag, marks the line valid, and then returns the requested word.

Every answer carries a two-bit outcome code that separates three cases: a hit, a miss on an empty line, and a miss that evicts another block from the same line. The requester sees a one-request-at-a-time port. A ready output shows when a request can be taken. The response is a one-cycle valid strobe together with the data and the outcome code. Toward memory the controller holds a word address together with a request flag, and it steps to the next word whenever memory raises its ready input.

With the default parameters the cache has 1024 lines of four 32-bit words each, which is 16 KB of data. Because nothing is ever written, every returned word equals the backing memory word at that address.

Top module: `dm_read_cache`

## Requirements
- R1: The address is split as tag = bits [ADDR_W-1:INDEX_W+4], index = bits [INDEX_W+3:4], word select = bits [3:2] and byte bits [1:0]. With the defaults this is an 18-bit tag in bits 31:14 and a 10-bit index in bits 13:4. All stored tag bits take part in the compare.
- R2: Reset clears every line's valid bit. The first access to any line after reset is therefore a miss on an empty line.
- R3: An access whose line is valid and whose stored tag equals the address tag is a hit. It reports outcome 2'b01, it is answered in the cycle after the request is accepted, and it issues no memory read.
- R4: An access to an invalid line reports outcome 2'b10. It fills the line, stores the tag and sets the valid bit, so that a repeat access to the same block hits.
- R5: An access to a valid line whose stored tag differs reports outcome 2'b11 and overwrites the line with the new block and tag. A later access to the evicted block misses with outcome 2'b11 again.
- R6: A fill issues exactly four word reads, at the block base address plus 0x0, 0x4, 0x8 and 0xC, in that order. Each read keeps mem_req high and mem_addr stable until a cycle in which mem_ready is high.
- R7: rsp_data always equals the backing memory word at the request address with bits 1:0 cleared. Address bits 3:2 select the word and bits 1:0 have no effect.
- R8: cpu_ready is low from the acceptance of a missing request until its response. The miss response appears one cycle after the cycle in which the last fill word is written.
- R9: rsp_kind is 2'b00 whenever rsp_valid is low, and it is never 2'b00 while rsp_valid is high.
- R10: cpu_ready is high in the cycle that presents a response, so a new request can be accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Read request, taken when cpu_ready is high |
| cpu_addr | input | ADDR_W | Byte address of the read |
| cpu_ready | output | 1 | Controller can take a request this cycle |
| rsp_valid | output | 1 | One-cycle strobe marking a response |
| rsp_data | output | WORD_W | Returned word |
| rsp_kind | output | 2 | Outcome: 01 hit, 10 empty-line miss, 11 eviction miss, 00 idle |
| mem_req | output | 1 | Word read request toward memory |
| mem_addr | output | ADDR_W | Word-aligned byte address of the memory read |
| mem_ready | input | 1 | Memory presents mem_rdata for mem_addr this cycle |
| mem_rdata | input | WORD_W | Memory read data |

## Verification
Two functions can meet in one cycle. The response strobe of one access can coincide with the acceptance of the next request, and a fill's last beat can land on a line that the following request indexes. The bench provokes both by issuing each request on the very cycle a response is seen. It runs index sweeps in which the first word of every line misses and the next three hit at once, and it uses random address streams over three tags that collide on the same lines. Each response is judged against a separate valid/tag model and an arithmetic memory image. The memory ready line stalls at random, so the beat-address order and the miss latency after the last beat are checked under back-pressure.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
   typedef enum logic [1:0] {
      KIND_NONE  = 2'b00,
      KIND_HIT   = 2'b01,
      KIND_COLD  = 2'b10,
      KIND_EVICT = 2'b11
   } access_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_FILL = 2'b01,
      ST_DONE = 2'b10
   } ctl_state_e;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
   parameter int ADDR_W  = 32,
   parameter int INDEX_W = 10,
   parameter int SEL_W   = 2,
   parameter int BSEL_W  = 2
) (
   input  logic [ADDR_W-1:0]                      addr,
   output logic [ADDR_W-INDEX_W-SEL_W-BSEL_W-1:0] tag,
   output logic [INDEX_W-1:0]                     index,
   output logic [SEL_W-1:0]                       word_sel
);
   localparam int OFFS_W = SEL_W + BSEL_W;

   assign tag      = addr[ADDR_W-1:INDEX_W+OFFS_W];
   assign index    = addr[INDEX_W+OFFS_W-1:OFFS_W];
   assign word_sel = addr[OFFS_W-1:BSEL_W];

   // Byte lanes inside a word play no part in a word-aligned read.
   wire unused_byte_bits = ^addr[BSEL_W-1:0];
endmodule

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
   parameter int INDEX_W = 10,
   parameter int TAG_W   = 18
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INDEX_W-1:0] rd_index,
   output logic               rd_valid,
   output logic [TAG_W-1:0]   rd_tag,
   input  logic               wr_en,
   input  logic [INDEX_W-1:0] wr_index,
   input  logic [TAG_W-1:0]   wr_tag
);
   localparam int LINES = 1 << INDEX_W;

   logic [LINES-1:0] valid_q;
   logic [TAG_W-1:0] tag_mem [LINES];

   // Valid bits live in flops so that reset empties every line at once.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_index] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_mem[wr_index] <= wr_tag;
      end
   end

   assign rd_valid = valid_q[rd_index];
   assign rd_tag   = tag_mem[rd_index];
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
   parameter int INDEX_W = 10,
   parameter int SEL_W   = 2,
   parameter int WORD_W  = 32
) (
   input  logic               clk,
   input  logic [INDEX_W-1:0] rd_index,
   input  logic [SEL_W-1:0]   rd_sel,
   output logic [WORD_W-1:0]  rd_data,
   input  logic               wr_en,
   input  logic [INDEX_W-1:0] wr_index,
   input  logic [SEL_W-1:0]   wr_sel,
   input  logic [WORD_W-1:0]  wr_data
);
   localparam int LINES = 1 << INDEX_W;
   localparam int BANKS = 1 << SEL_W;

   logic [WORD_W-1:0] bank_rd [BANKS];

   // One bank per word position: a fill beat writes exactly one bank.
   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic [WORD_W-1:0] cells [LINES];
      logic              bank_we;

      assign bank_we = wr_en && (wr_sel == SEL_W'(b));

      always_ff @(posedge clk) begin
         if (bank_we) begin
            cells[wr_index] <= wr_data;
         end
      end

      assign bank_rd[b] = cells[rd_index];
   end

   assign rd_data = bank_rd[rd_sel];
endmodule

// File: rtl/dmc_fill_ctrl.sv
module dmc_fill_ctrl
   import dmc_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int WORD_W  = 32,
   parameter int INDEX_W = 10,
   parameter int SEL_W   = 2,
   parameter int BSEL_W  = 2,
   parameter int TAG_W   = 18
) (
   input  logic               clk,
   input  logic               rst_n,
   // requester side
   input  logic               cpu_req,
   output logic               cpu_ready,
   input  logic [TAG_W-1:0]   in_tag,
   input  logic [INDEX_W-1:0] in_index,
   input  logic [SEL_W-1:0]   in_sel,
   // lookup results from the stores
   input  logic               look_valid,
   input  logic [TAG_W-1:0]   look_tag,
   input  logic [WORD_W-1:0]  look_word,
   // store addressing and writes
   output logic               use_held,
   output logic [INDEX_W-1:0] held_index,
   output logic [SEL_W-1:0]   held_sel,
   output logic [TAG_W-1:0]   held_tag,
   output logic               fill_we,
   output logic [SEL_W-1:0]   fill_sel,
   output logic               tag_we,
   // memory side
   output logic               mem_req,
   output logic [ADDR_W-1:0]  mem_addr,
   input  logic               mem_ready,
   // response
   output logic               rsp_valid,
   output logic [WORD_W-1:0]  rsp_data,
   output logic [1:0]         rsp_kind
);
   localparam logic [SEL_W-1:0] LAST_BEAT = '1;

   ctl_state_e   state_q;
   logic [SEL_W-1:0] beat_q;
   access_kind_e pend_kind_q;
   access_kind_e kind_q;
   logic         lookup_hit;
   logic         accept;

   assign cpu_ready  = (state_q == ST_IDLE);
   assign accept     = cpu_req && cpu_ready;
   assign lookup_hit = look_valid && (look_tag == in_tag);
   assign use_held   = (state_q != ST_IDLE);

   assign mem_req  = (state_q == ST_FILL);
   assign mem_addr = {held_tag, held_index, beat_q, {BSEL_W{1'b0}}};
   assign fill_we  = mem_req && mem_ready;
   assign fill_sel = beat_q;
   assign tag_we   = fill_we && (beat_q == LAST_BEAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         beat_q      <= '0;
         held_tag    <= '0;
         held_index  <= '0;
         held_sel    <= '0;
         pend_kind_q <= KIND_NONE;
         rsp_valid   <= 1'b0;
         rsp_data    <= '0;
         kind_q      <= KIND_NONE;
      end else begin
         rsp_valid <= 1'b0;
         kind_q    <= KIND_NONE;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  held_tag   <= in_tag;
                  held_index <= in_index;
                  held_sel   <= in_sel;
                  if (lookup_hit) begin
                     rsp_valid <= 1'b1;
                     rsp_data  <= look_word;
                     kind_q    <= KIND_HIT;
                  end else begin
                     pend_kind_q <= look_valid ? KIND_EVICT : KIND_COLD;
                     beat_q      <= '0;
                     state_q     <= ST_FILL;
                  end
               end
            end
            ST_FILL: begin
               if (mem_ready) begin
                  beat_q <= beat_q + 1'b1;
                  if (beat_q == LAST_BEAT) begin
                     state_q <= ST_DONE;
                  end
               end
            end
            ST_DONE: begin
               // The line was completed on the previous edge; read it back.
               rsp_valid <= 1'b1;
               rsp_data  <= look_word;
               kind_q    <= pend_kind_q;
               state_q   <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign rsp_kind = kind_q;
endmodule

// File: rtl/dm_read_cache.sv
module dm_read_cache #(
   parameter int ADDR_W     = 32,
   parameter int WORD_W     = 32,
   parameter int INDEX_W    = 10,
   parameter int LINE_WORDS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic              cpu_ready,
   output logic              rsp_valid,
   output logic [WORD_W-1:0] rsp_data,
   output logic [1:0]        rsp_kind,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ready,
   input  logic [WORD_W-1:0] mem_rdata
);
   localparam int SEL_W  = $clog2(LINE_WORDS);
   localparam int BSEL_W = $clog2(WORD_W / 8);
   localparam int OFFS_W = SEL_W + BSEL_W;
   localparam int TAG_W  = ADDR_W - INDEX_W - OFFS_W;

   // Elaboration-time parameter checks
   if (LINE_WORDS < 2 || (LINE_WORDS & (LINE_WORDS - 1)) != 0) begin : g_bad_line
      $error("LINE_WORDS must be a power of two of at least 2");
   end
   if (WORD_W < 8 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_word
      $error("WORD_W must be a power-of-two number of bits, 8 or more");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W leaves no tag bits");
   end

   logic [TAG_W-1:0]   in_tag;
   logic [INDEX_W-1:0] in_index;
   logic [SEL_W-1:0]   in_sel;
   logic               use_held;
   logic [INDEX_W-1:0] held_index;
   logic [SEL_W-1:0]   held_sel;
   logic [TAG_W-1:0]   held_tag;
   logic [INDEX_W-1:0] look_index;
   logic [SEL_W-1:0]   look_sel;
   logic               look_valid;
   logic [TAG_W-1:0]   look_tag;
   logic [WORD_W-1:0]  look_word;
   logic               fill_we;
   logic [SEL_W-1:0]   fill_sel;
   logic               tag_we;

   dmc_addr_split #(
      .ADDR_W (ADDR_W),
      .INDEX_W(INDEX_W),
      .SEL_W  (SEL_W),
      .BSEL_W (BSEL_W)
   ) u_split (
      .addr    (cpu_addr),
      .tag     (in_tag),
      .index   (in_index),
      .word_sel(in_sel)
   );

   assign look_index = use_held ? held_index : in_index;
   assign look_sel   = use_held ? held_sel   : in_sel;

   dmc_tag_store #(
      .INDEX_W(INDEX_W),
      .TAG_W  (TAG_W)
   ) u_tags (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_index(look_index),
      .rd_valid(look_valid),
      .rd_tag  (look_tag),
      .wr_en   (tag_we),
      .wr_index(held_index),
      .wr_tag  (held_tag)
   );

   dmc_data_store #(
      .INDEX_W(INDEX_W),
      .SEL_W  (SEL_W),
      .WORD_W (WORD_W)
   ) u_data (
      .clk     (clk),
      .rd_index(look_index),
      .rd_sel  (look_sel),
      .rd_data (look_word),
      .wr_en   (fill_we),
      .wr_index(held_index),
      .wr_sel  (fill_sel),
      .wr_data (mem_rdata)
   );

   dmc_fill_ctrl #(
      .ADDR_W (ADDR_W),
      .WORD_W (WORD_W),
      .INDEX_W(INDEX_W),
      .SEL_W  (SEL_W),
      .BSEL_W (BSEL_W),
      .TAG_W  (TAG_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_req   (cpu_req),
      .cpu_ready (cpu_ready),
      .in_tag    (in_tag),
      .in_index  (in_index),
      .in_sel    (in_sel),
      .look_valid(look_valid),
      .look_tag  (look_tag),
      .look_word (look_word),
      .use_held  (use_held),
      .held_index(held_index),
      .held_sel  (held_sel),
      .held_tag  (held_tag),
      .fill_we   (fill_we),
      .fill_sel  (fill_sel),
      .tag_we    (tag_we),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .mem_ready (mem_ready),
      .rsp_valid (rsp_valid),
      .rsp_data  (rsp_data),
      .rsp_kind  (rsp_kind)
   );
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
   parameter int ADDR_W = 32,
   parameter int OFFS_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_ready,
   input logic              rsp_valid,
   input logic [1:0]        rsp_kind,
   input logic              mem_req,
   input logic              mem_ready,
   input logic [ADDR_W-1:0] mem_addr
);
   // R6: a stalled beat holds its request and address
   assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr));

   // R6: a fill starts at the block base
   assert_fill_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> mem_addr[OFFS_W-1:0] == '0);

   // R8: no new request is taken while memory is being read
   assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !cpu_ready);

   // R8: miss response follows the fill with exactly one quiet cycle
   assert_miss_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_kind[1] |-> !$past(mem_req) && $past(mem_req, 2));

   // R3: a hit answers the request accepted on the previous edge
   assert_hit_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_kind == 2'b01 |-> $past(cpu_req && cpu_ready) && !$past(mem_req));

   // R9: outcome code is idle exactly when no response is presented
   assert_kind_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> rsp_kind == 2'b00);
   assert_kind_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_kind != 2'b00);

   // R10: a response cycle is also a cycle that can take a request
   assert_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> cpu_ready);
endmodule

bind dm_read_cache dmc_checker #(
   .ADDR_W(ADDR_W),
   .OFFS_W(OFFS_W)
) u_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .cpu_req  (cpu_req),
   .cpu_ready(cpu_ready),
   .rsp_valid(rsp_valid),
   .rsp_kind (rsp_kind),
   .mem_req  (mem_req),
   .mem_ready(mem_ready),
   .mem_addr (mem_addr)
);

// File: tb/dm_read_cache_test.sv
`timescale 1ns/1ps
module dm_read_cache_test;
   localparam int AW = 32;
   localparam int WW = 32;
   localparam int IW = 4;
   localparam int NL = 1 << IW;
   localparam int TW = AW - IW - 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic          cpu_ready;
   logic          rsp_valid;
   logic [WW-1:0] rsp_data;
   logic [1:0]    rsp_kind;
   logic          mem_req;
   logic [AW-1:0] mem_addr;
   logic          mem_ready = 1'b0;
   logic [WW-1:0] mem_rdata;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   int beat_cnt = 0;
   int last_beat_cyc = 0;
   logic [AW-1:0] exp_base = '0;
   logic [15:0] lf = 16'hACE1;
   bit done = 0;

   bit          m_valid [NL];
   logic [TW-1:0] m_tag [NL];

   always #2 clk = ~clk;

   dm_read_cache #(.ADDR_W(AW), .WORD_W(WW), .INDEX_W(IW), .LINE_WORDS(4)) uut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
      .cpu_ready(cpu_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .rsp_kind(rsp_kind), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_ready(mem_ready), .mem_rdata(mem_rdata));

   function automatic logic [WW-1:0] word_at(input logic [AW-1:0] a);
      return (a & 32'hFFFF_FFFC) * 32'h9E37_79B1 + 32'h00C0_FFEE;
   endfunction

   assign mem_rdata = word_at(mem_addr);

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   // Memory model: random stalls, beat address order checked (R6)
   always @(negedge clk) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      mem_ready = (lf[1:0] != 2'b00);
      if (mem_req && mem_ready) begin
         chk(mem_addr == exp_base + 32'(4 * beat_cnt), "R6 beat address", mem_addr, exp_base + 32'(4 * beat_cnt));
         beat_cnt++;
         last_beat_cyc = cyc;
      end
   end

   task automatic access(input logic [AW-1:0] a);
      logic [TW-1:0] t;
      int idx;
      logic [1:0] ek;
      int lat;
      bit busy_ok;
      t   = a[AW-1:IW+4];
      idx = int'(a[IW+3:4]);
      if (!m_valid[idx]) ek = 2'b10;
      else if (m_tag[idx] != t) ek = 2'b11;
      else ek = 2'b01;
      m_valid[idx] = 1;
      m_tag[idx] = t;
      exp_base = {a[AW-1:4], 4'h0};
      beat_cnt = 0;
      while (!cpu_ready) @(negedge clk);
      cpu_req = 1'b1;
      cpu_addr = a;
      @(negedge clk);
      cpu_req = 1'b0;
      lat = 1;
      busy_ok = 1;
      while (!rsp_valid && lat < 200) begin
         if (cpu_ready) busy_ok = 0;
         @(negedge clk);
         lat++;
      end
      chk(rsp_kind == ek, (ek == 2'b01) ? "R3 hit kind" : (ek == 2'b10) ? "R4 cold kind" : "R5 evict kind", rsp_kind, ek);
      chk(rsp_data == word_at(a), "R7 data", rsp_data, word_at(a));
      chk(cpu_ready, "R10 ready with response", cpu_ready, 1);
      if (ek == 2'b01) begin
         chk(lat == 1, "R3 hit latency", lat, 1);
         chk(beat_cnt == 0, "R3 no memory read", beat_cnt, 0);
      end else begin
         chk(beat_cnt == 4, "R6 beat count", beat_cnt, 4);
         chk(cyc == last_beat_cyc + 2, "R8 miss latency", cyc, last_beat_cyc + 2);
         chk(busy_ok, "R8 ready low during fill", busy_ok, 1);
      end
   endtask

   function automatic logic [AW-1:0] mk(input logic [TW-1:0] t, input int idx, input int w, input int b);
      return {t, IW'(idx), 2'(w), 2'(b)};
   endfunction

   initial begin
      for (int i = 0; i < NL; i++) begin m_valid[i] = 0; m_tag[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cpu_ready == 1, "R2 reset ready", cpu_ready, 1);
      chk(rsp_valid == 0, "R9 reset no response", rsp_valid, 0);
      chk(rsp_kind == 0, "R9 reset kind idle", rsp_kind, 0);
      chk(mem_req == 0, "R2 reset no memory read", mem_req, 0);

      // R2, R4, R3: sweep every line and word, byte bits varied (R7)
      for (int i = 0; i < NL; i++)
         for (int w = 0; w < 4; w++)
            access(mk(24'h000001, i, w, (i + w) % 4));
      // R5: conflicting tag on every line
      for (int i = 0; i < NL; i++)
         for (int w = 3; w >= 0; w--)
            access(mk(24'h800002, i, w, w));
      // R1: tags differing only in the lowest bit collide and evict
      access(mk(24'h800003, 7, 1, 0));
      access(mk(24'h800002, 7, 2, 3));
      // mixed stream over three tags
      for (int n = 0; n < 300; n++) begin
         logic [15:0] r;
         logic [TW-1:0] tg;
         r = 16'(n * 40503 + 17);
         tg = (r[15:14] == 2'd0) ? 24'h000001 : (r[15:14] == 2'd1) ? 24'h800002 : 24'h3C5A96;
         access(mk(tg, int'(r[7:4]), int'(r[3:2]), int'(r[1:0])));
      end
      // R9: idle cycles carry no response
      repeat (3) @(negedge clk);
      chk(rsp_valid == 0 && rsp_kind == 0, "R9 idle", {rsp_valid, rsp_kind}, 0);
      // R2: reset mid-run empties lines
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NL; i++) m_valid[i] = 0;
      @(negedge clk);
      access(mk(24'h800002, 5, 0, 0));
      access(mk(24'h800002, 5, 3, 1));
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule